// File: doc/BRIEF.md
# Debug trigger state sequencer

This block is the decision core of an on-chip debug unit. Four address comparator channels report hits in two flavours. A forced hit arrives as soon as the address appears on the bus. A tagged hit arrives later, when the tagged instruction reaches execution. The sequencer also accepts software pulses to arm, to disarm and to trigger immediately. Once armed, it walks through three intermediate states toward a final state. For each state a control word chooses where each channel's hit leads.

When several channels hit in the same cycle, one winner is chosen by fixed priority and the rest are dropped. A hit that leads to the final state beats any hit that does not. Among equals, the lowest channel number wins. In range mode, a hit on channel 0 hides a simultaneous hit on channel 2.

On reaching the final state, the trace alignment mode decides what happens next:
- Begin alignment starts a trace window.
- Mid alignment finishes a shortened trace window.
- End alignment closes the session at once.

When the session closes, the block can raise a one-cycle breakpoint request. It also keeps status flags that describe the trigger which fired.

Top module: `dbg_trigger_seq`

## Requirements
- R1: After reset the sequencer is disarmed (`seq_state` = 0, `armed` = 0, `bkpt_req` = 0, `trace_on` = 0). From the disarmed state, an `sw_arm` pulse moves it to state 1 (`seq_state` = 1) on the next clock edge and clears every status flag. While armed, `sw_arm` is ignored. From any armed state, `sw_disarm` returns it to 0 without a breakpoint request.
- R2: Channel n triggers when `forced_hit[n]` or `tagged_hit[n]` is high. In state s (1..3), the 3-bit code at bits [3n+2:3n] of that state's control word (`ctrl_s1`, `ctrl_s2`, `ctrl_s3`) chooses the next state: 1, 2 or 3 for states 1 to 3, and 4 for the final state. Codes 0, 5, 6 and 7 make that channel's hit ignored in that state.
- R3: Among simultaneous effective hits, the lowest channel number wins. Losing hits are dropped and do not act on a later cycle.
- R4: A hit whose code is 4 (final) wins over every hit whose code is not 4, whatever the channel numbers.
- R5: When `range_mode` = 1, a hit on channel 2 is ignored in any cycle in which channel 0 also hits, even if channel 2 leads to the final state.
- R6: On a comparator transition, `st_valid` is set and `st_ch` takes the winning channel. `st_tag` is 1 only if the winner's hit was tagged and not also forced. `st_final` is set when the target is the final state.
- R7: Under begin alignment (`align` = 00) or mid alignment (01), `sw_trig` in states 1 to 3 moves the sequencer to the final state (`seq_state` = 4) and sets `st_sw` and `st_final`.
- R8: Under end alignment (`align` = 1x), `sw_trig` in states 1 to 3 disarms on the next edge. It pulses `trace_done`, pulses `bkpt_req` when `bkpt_en` = 1, and sets `st_sw`.
- R9: Under begin alignment, `trace_on` is high only in the final state. Under mid or end alignment, `trace_on` is high in every armed state. The final state lasts TRACE_DEPTH cycles under begin alignment and TRACE_DEPTH/2 cycles under mid alignment. The sequencer then disarms, pulses `trace_done` and pulses `bkpt_req` when `bkpt_en` = 1.
- R10: Under end alignment, a comparator hit that leads to the final state disarms on the same edge. It pulses `trace_done` and `bkpt_req` (when enabled) and sets `st_final`.
- R11: `bkpt_req` is never high when `bkpt_en` was low at the closing edge, and it never stays high for two cycles.
- R12: If `sw_arm` coincides with a hardware disarm (a session closing on that edge), the sequencer ends disarmed.
- R13: While in the final state, comparator hits and `sw_trig` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_arm | input | 1 | Software arm pulse |
| sw_disarm | input | 1 | Software disarm pulse |
| sw_trig | input | 1 | Software immediate-trigger pulse |
| bkpt_en | input | 1 | Allow breakpoint requests |
| range_mode | input | 1 | Channel 0 hides a simultaneous channel 2 hit |
| align | input | 2 | Trace alignment: 00 begin, 01 mid, 1x end |
| forced_hit | input | NCH | Bus-time comparator hits |
| tagged_hit | input | NCH | Execute-time comparator hits |
| ctrl_s1 | input | 3*NCH | Next-state codes used in state 1 |
| ctrl_s2 | input | 3*NCH | Next-state codes used in state 2 |
| ctrl_s3 | input | 3*NCH | Next-state codes used in state 3 |
| armed | output | 1 | Sequencer is not disarmed |
| seq_state | output | 3 | 0 disarmed, 1..3 intermediate, 4 final |
| trace_on | output | 1 | Trace capture window is open |
| trace_done | output | 1 | One-cycle pulse when a session closes by trigger |
| bkpt_req | output | 1 | One-cycle breakpoint request |
| st_valid | output | 1 | A comparator transition occurred since arming |
| st_final | output | 1 | The final state was reached or targeted |
| st_sw | output | 1 | The software trigger fired |
| st_tag | output | 1 | The last comparator winner was tagged only |
| st_ch | output | $clog2(NCH) | Channel of the last comparator winner |

## Verification
A wrong priority decision shows up on the edge right after the hit. `seq_state` moves to the loser's target, and `st_ch` names the wrong channel. A bad final-state counter shows up as `seq_state` leaving 4 one or more cycles early or late, and `trace_done` and `bkpt_req` move with it. A stale state after a dropped hit, or a wrongly latched arm during a hardware disarm, shows as a state change on a cycle with no stimulus. The bench watches for this on the cycle after each such event.

// File: rtl/dbg_trigger_seq.sv
module dbg_trigger_seq #(
  parameter int NCH = 4,
  parameter int TRACE_DEPTH = 8,
  localparam int CW = 3,
  localparam int CHW = $clog2(NCH),
  localparam int CTRLW = NCH * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_arm,
  input  logic             sw_disarm,
  input  logic             sw_trig,
  input  logic             bkpt_en,
  input  logic             range_mode,
  input  logic [1:0]       align,
  input  logic [NCH-1:0]   forced_hit,
  input  logic [NCH-1:0]   tagged_hit,
  input  logic [CTRLW-1:0] ctrl_s1,
  input  logic [CTRLW-1:0] ctrl_s2,
  input  logic [CTRLW-1:0] ctrl_s3,
  output logic             armed,
  output logic [2:0]       seq_state,
  output logic             trace_on,
  output logic             trace_done,
  output logic             bkpt_req,
  output logic             st_valid,
  output logic             st_final,
  output logic             st_sw,
  output logic             st_tag,
  output logic [CHW-1:0]   st_ch
);
  localparam int CNTW = $clog2(TRACE_DEPTH) + 1;
  localparam logic [2:0] ST_IDLE = 3'd0, ST_S1 = 3'd1, ST_S2 = 3'd2, ST_S3 = 3'd3, ST_FIN = 3'd4;

  logic [2:0]       state_q;
  logic [CNTW-1:0]  cnt_q;
  logic [CTRLW-1:0] ctrl_cur;
  logic [NCH-1:0]   hit, valid, fin;
  logic [CW-1:0]    code [NCH];
  logic [CHW-1:0]   sel_ch;
  logic [CW-1:0]    sel_code;

  wire end_al   = align[1];
  wire in_seq   = (state_q == ST_S1) || (state_q == ST_S2) || (state_q == ST_S3);
  wire [CNTW-1:0] post_len = (align == 2'b01) ? CNTW'(TRACE_DEPTH / 2) : CNTW'(TRACE_DEPTH);

  always_comb begin
    case (state_q)
      ST_S1:   ctrl_cur = ctrl_s1;
      ST_S2:   ctrl_cur = ctrl_s2;
      ST_S3:   ctrl_cur = ctrl_s3;
      default: ctrl_cur = '0;
    endcase
  end

  wire ch0_any = forced_hit[0] | tagged_hit[0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == 2) begin : g_rng
      assign hit[g] = (forced_hit[g] | tagged_hit[g]) & ~(range_mode & ch0_any);
    end else begin : g_plain
      assign hit[g] = forced_hit[g] | tagged_hit[g];
    end
    assign code[g]  = ctrl_cur[g*CW +: CW];
    assign valid[g] = hit[g] && (code[g] >= 3'd1) && (code[g] <= ST_FIN);
    assign fin[g]   = hit[g] && (code[g] == ST_FIN);
  end

  always_comb begin
    sel_ch = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if ((|fin) ? fin[i] : valid[i]) sel_ch = CHW'(i);
  end

  assign sel_code = code[sel_ch];

  wire sw_fire  = in_seq && sw_trig && !sw_disarm;
  wire cmp_fire = in_seq && !sw_trig && !sw_disarm && (|valid);
  wire fin_done = (state_q == ST_FIN) && !sw_disarm && (cnt_q == post_len - 1'b1);
  wire hw_end   = (sw_fire && end_al) || (cmp_fire && end_al && sel_code == ST_FIN) || fin_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bkpt_req   <= 1'b0;
      trace_done <= 1'b0;
      st_valid   <= 1'b0;
      st_final   <= 1'b0;
      st_sw      <= 1'b0;
      st_tag     <= 1'b0;
      st_ch      <= '0;
    end else begin
      bkpt_req   <= 1'b0;
      trace_done <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (sw_arm) begin
          state_q  <= ST_S1;
          cnt_q    <= '0;
          st_valid <= 1'b0;
          st_final <= 1'b0;
          st_sw    <= 1'b0;
          st_tag   <= 1'b0;
          st_ch    <= '0;
        end
      end else if (sw_disarm) begin
        state_q <= ST_IDLE;
      end else begin
        if (sw_fire) begin
          st_sw <= 1'b1;
          if (!end_al) st_final <= 1'b1;
        end else if (cmp_fire) begin
          st_valid <= 1'b1;
          st_ch    <= sel_ch;
          st_tag   <= !forced_hit[sel_ch];
          if (sel_code == ST_FIN) st_final <= 1'b1;
        end
        if (hw_end) begin
          state_q    <= ST_IDLE;
          bkpt_req   <= bkpt_en;
          trace_done <= 1'b1;
        end else if (sw_fire) begin
          state_q <= ST_FIN;
          cnt_q   <= '0;
        end else if (cmp_fire) begin
          state_q <= sel_code;
          cnt_q   <= '0;
        end else if (state_q == ST_FIN) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign armed     = (state_q != ST_IDLE);
  assign seq_state = state_q;
  assign trace_on  = armed && ((align != 2'b00) || (state_q == ST_FIN));

  p_arm_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sw_arm) |=> (state_q == ST_S1 && !st_valid && !st_sw && !st_final));
  p_disarm_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && sw_disarm) |=> (state_q == ST_IDLE && !bkpt_req && !trace_done));
  p_bkpt_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_req |=> !bkpt_req);
  p_bkpt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_req || trace_done) |-> (state_q == ST_IDLE));
  p_end_swtrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && align[1] && sw_trig && !sw_disarm) |=> (state_q == ST_IDLE && trace_done && st_sw));
  p_begin_trace_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (align == 2'b00 && state_q != ST_FIN) |-> !trace_on);
  p_arm_race_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && align[1] && sw_trig && sw_arm) |=> (state_q == ST_IDLE));
  p_final_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN && !sw_disarm && cnt_q + 1'b1 < post_len) |=> (state_q == ST_FIN));
endmodule

// File: tb/dbg_trigger_seq_bench.sv
`timescale 1ns/100ps
module dbg_trigger_seq_bench;
  localparam int NCH = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_arm = 0, sw_disarm = 0, sw_trig = 0, bkpt_en = 0, range_mode = 0;
  logic [1:0] align = 2'b00;
  logic [NCH-1:0] forced_hit = '0, tagged_hit = '0;
  logic [3*NCH-1:0] ctrl_s1 = '0, ctrl_s2 = '0, ctrl_s3 = '0;
  logic armed, trace_on, trace_done, bkpt_req, st_valid, st_final, st_sw, st_tag;
  logic [2:0] seq_state;
  logic [1:0] st_ch;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  dbg_trigger_seq #(.NCH(NCH), .TRACE_DEPTH(DEPTH)) u_dbg_trigger_seq (
    .clk(clk), .rst_n(rst_n), .sw_arm(sw_arm), .sw_disarm(sw_disarm), .sw_trig(sw_trig),
    .bkpt_en(bkpt_en), .range_mode(range_mode), .align(align),
    .forced_hit(forced_hit), .tagged_hit(tagged_hit),
    .ctrl_s1(ctrl_s1), .ctrl_s2(ctrl_s2), .ctrl_s3(ctrl_s3),
    .armed(armed), .seq_state(seq_state), .trace_on(trace_on), .trace_done(trace_done),
    .bkpt_req(bkpt_req), .st_valid(st_valid), .st_final(st_final), .st_sw(st_sw),
    .st_tag(st_tag), .st_ch(st_ch));

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_arm();
    sw_arm = 1; tick(); sw_arm = 0;
  endtask

  task automatic do_disarm();
    sw_disarm = 1; tick(); sw_disarm = 0;
  endtask

  function automatic logic [11:0] pack4(input int c0, input int c1, input int c2, input int c3);
    return {3'(c3), 3'(c2), 3'(c1), 3'(c0)};
  endfunction

  // winner per R2..R5: -1 when no effective hit
  function automatic int winner(input logic [3:0] pat, input logic [11:0] cfg, input logic rng);
    int best_fin, best_any, c;
    best_fin = -1; best_any = -1;
    for (int n = 3; n >= 0; n--) begin
      c = int'(cfg[n*3 +: 3]);
      if (pat[n] && !(rng && n == 2 && pat[0]) && c >= 1 && c <= 4) begin
        best_any = n;
        if (c == 4) best_fin = n;
      end
    end
    return (best_fin >= 0) ? best_fin : best_any;
  endfunction

  initial begin
    #(5.0 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [11:0] cfgs [3];
    cfgs[0] = pack4(2, 3, 4, 1);
    cfgs[1] = pack4(0, 4, 3, 4);
    cfgs[2] = pack4(5, 2, 4, 7);
    #7; tick();
    rst_n = 1; tick();
    chk("R1 reset state", seq_state, 0);
    chk("R1 reset armed", armed, 0);
    chk("R1 reset bkpt", bkpt_req, 0);
    chk("R1 reset trace_on", trace_on, 0);

    // R2..R6 sweep over configs, patterns, range mode and flavour
    bkpt_en = 1; align = 2'b00;
    for (int ci = 0; ci < 3; ci++)
      for (int rg = 0; rg < 2; rg++)
        for (int fl = 0; fl < 3; fl++)
          for (int p = 1; p < 16; p++) begin
            int w;
            ctrl_s1 = cfgs[ci]; range_mode = rg[0];
            do_arm();
            w = winner(4'(p), cfgs[ci], rg[0]);
            forced_hit = (fl != 1) ? 4'(p) : 4'd0;
            tagged_hit = (fl != 0) ? 4'(p) : 4'd0;
            tick();
            forced_hit = '0; tagged_hit = '0;
            if (w < 0) begin
              chk("R2 no effective hit keeps state 1", seq_state, 1);
              chk("R6 valid stays clear", st_valid, 0);
            end else begin
              chk("R2/R3/R4/R5 next state", seq_state, int'(cfgs[ci][w*3 +: 3]));
              chk("R6 winner channel", st_ch, w);
              chk("R6 tag flavour", st_tag, (fl == 1) ? 1 : 0);
              chk("R6 final flag", st_final, (cfgs[ci][w*3 +: 3] == 3'd4) ? 1 : 0);
            end
            do_disarm();
            chk("R1 disarm to idle", seq_state, 0);
          end
    range_mode = 0;

    // R3 dropped losers, multi-step walk, R10 end via comparator
    align = 2'b10; bkpt_en = 1;
    ctrl_s1 = pack4(2, 3, 0, 0);
    ctrl_s2 = pack4(0, 0, 3, 0);
    ctrl_s3 = pack4(4, 0, 0, 0);
    do_arm();
    chk("R9 end align trace on while armed", trace_on, 1);
    sw_arm = 1; tick(); sw_arm = 0;
    chk("R1 arm ignored while armed", seq_state, 1);
    forced_hit = 4'b0011; tick(); forced_hit = '0;
    chk("R3 lowest channel wins", seq_state, 2);
    tick();
    chk("R3 loser not queued", seq_state, 2);
    forced_hit = 4'b0001; tick(); forced_hit = '0;
    chk("R2 code 0 ignored in state 2", seq_state, 2);
    forced_hit = 4'b0100; tick(); forced_hit = '0;
    chk("R2 state 2 to 3", seq_state, 3);
    tagged_hit = 4'b0001; tick(); tagged_hit = '0;
    chk("R10 end align comparator disarms", seq_state, 0);
    chk("R10 bkpt pulse", bkpt_req, 1);
    chk("R10 trace_done", trace_done, 1);
    chk("R10 final flag", st_final, 1);
    chk("R6 tagged winner", st_tag, 1);
    tick();
    chk("R11 bkpt single cycle", bkpt_req, 0);

    // R8 software trigger under end alignment, with and without breakpoints
    do_arm();
    sw_trig = 1; tick(); sw_trig = 0;
    chk("R8 sw trig end disarms", seq_state, 0);
    chk("R8 bkpt when enabled", bkpt_req, 1);
    chk("R8 sw flag", st_sw, 1);
    bkpt_en = 0;
    do_arm();
    chk("R1 rearm clears sw flag", st_sw, 0);
    sw_trig = 1; tick(); sw_trig = 0;
    chk("R11 no bkpt when disabled", bkpt_req, 0);
    chk("R8 trace_done", trace_done, 1);

    // R12 arm write colliding with hardware disarm
    bkpt_en = 1;
    ctrl_s1 = pack4(4, 0, 0, 0);
    do_arm();
    forced_hit = 4'b0001; sw_arm = 1; tick(); forced_hit = '0; sw_arm = 0;
    chk("R12 hw disarm beats arm", armed, 0);
    tick();
    chk("R12 stays disarmed", seq_state, 0);

    // R7, R9, R13 begin alignment
    align = 2'b00;
    do_arm();
    chk("R9 begin align no trace before final", trace_on, 0);
    sw_trig = 1; tick(); sw_trig = 0;
    chk("R7 sw trig to final", seq_state, 4);
    chk("R7 sw flag", st_sw, 1);
    chk("R7 final flag", st_final, 1);
    chk("R9 trace on in final", trace_on, 1);
    forced_hit = 4'b1111; sw_trig = 1; tick(); forced_hit = '0; sw_trig = 0;
    chk("R13 final ignores triggers", seq_state, 4);
    chk("R13 valid untouched", st_valid, 0);
    for (int k = 2; k < DEPTH; k++) begin
      tick();
      chk("R9 begin final window", seq_state, 4);
    end
    tick();
    chk("R9 begin window end", seq_state, 0);
    chk("R9 begin bkpt", bkpt_req, 1);
    chk("R9 begin trace_done", trace_done, 1);
    tick();
    chk("R11 bkpt single cycle", bkpt_req, 0);

    // R9 mid alignment, shorter window, breakpoints off
    align = 2'b01; bkpt_en = 0;
    do_arm();
    chk("R9 mid trace on from arm", trace_on, 1);
    sw_trig = 1; tick(); sw_trig = 0;
    chk("R7 mid sw trig to final", seq_state, 4);
    for (int k = 1; k < DEPTH / 2; k++) begin
      tick();
      chk("R9 mid final window", seq_state, 4);
    end
    tick();
    chk("R9 mid window end", seq_state, 0);
    chk("R11 mid no bkpt when disabled", bkpt_req, 0);
    chk("R9 mid trace_done", trace_done, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule